// File: doc/BRIEF.md
# Position Snapshot Hold Registers

This block sits between a quadrature position counter and a 16-bit register bus. It lets software read a 32-bit position, a revolution count and a difference count through 16-bit reads without tearing. When software reads any live counter address, the block copies all three live counter values into hold registers on that clock edge. Software reads the upper position half live and then takes the lower half from the hold copy, so the two halves always belong to the same instant.

An external trigger input can also clear things. When its enable is set, the trigger issues a clear pulse to the live position counter, which sits outside this block. When a second enable is set, the trigger zeroes the held position. Read data is combinational from the address and read enable. A snapshot taken in a cycle is visible to reads from the next cycle on.

Top module: `enc_snap_hold`

## Requirements
- R1: After reset all hold registers read as zero and both clear pulse outputs are low.
- R2: On a clock edge where `rd_en_i` is high and `rd_addr_i` is a live counter address (0, 1, 4 or 6), `pos_i`, `rev_i` and `diff_i` are copied into the held position, held revolution and held difference.
- R3: A read of a hold address (2, 3, 5 or 7) leaves all hold registers unchanged.
- R4: Address 0 returns `pos_i[31:16]` in the same cycle. Address 1 returns bits 15:0 of the held position, so this read returns the value held before the edge at which it takes its own snapshot.
- R5: Address 2 returns held position bits 31:16 and address 3 returns bits 15:0. Address 4 returns live `rev_i` and address 5 the held revolution. Address 6 returns live `diff_i` and address 7 the held difference.
- R6: When `trig_i` and `clr_pos_en_i` are both high at a clock edge, `pos_clr_o` is high for exactly the following cycle. Otherwise `pos_clr_o` stays low.
- R7: When `trig_i` and `clr_hold_en_i` are both high at a clock edge, the held position becomes zero and `hold_clr_o` is high for the following cycle. The held revolution and held difference are not affected.
- R8: If a snapshot and a held-position clear fall on the same edge, the snapshot wins. The held position takes `pos_i`, which is the value from before any clear of the live counter.
- R9: While `rd_en_i` is low, `rd_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pos_i | input | 32 | Live position counter value |
| rev_i | input | 16 | Live revolution counter value |
| diff_i | input | 16 | Live difference counter value |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 3 | Register address of the read |
| rd_data_o | output | 16 | Read data |
| trig_i | input | 1 | External trigger pulse |
| clr_pos_en_i | input | 1 | Lets the trigger clear the live position counter |
| clr_hold_en_i | input | 1 | Lets the trigger clear the held position |
| pos_clr_o | output | 1 | Clear pulse to the live position counter |
| hold_clr_o | output | 1 | Pulse marking a held-position clear |

## Verification
A wrong hold register state shows up at the ports as soon as the next read of a hold address or of address 1. Such a read can come in the cycle right after the snapshot edge. The bench therefore checks every address in every cycle of a sweep that mixes snapshots, hold clears and plain reads. In that sweep, a missed snapshot, a spurious one, or the wrong priority between a snapshot and a clear changes the very next returned word. A wrong trigger path shows up one cycle later as a missing or extra clear pulse.

// File: rtl/enc_snap_pkg.sv
package enc_snap_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_POS_HI  = 3'd0,
      A_POS_LO  = 3'd1,
      A_POSH_HI = 3'd2,
      A_POSH_LO = 3'd3,
      A_REV     = 3'd4,
      A_REVH    = 3'd5,
      A_DIFF    = 3'd6,
      A_DIFFH   = 3'd7
   } snap_addr_e;

   function automatic logic is_live_addr(input logic [ADDR_W-1:0] a);
      case (a)
         A_POS_HI, A_POS_LO, A_REV, A_DIFF: return 1'b1;
         default:                           return 1'b0;
      endcase
   endfunction
endpackage

// File: rtl/snap_trig_ctl.sv
module snap_trig_ctl #(
   parameter bit TRIG_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic clr_pos_en_i,
   input  logic clr_hold_en_i,
   output logic hclr_now_o,
   output logic pos_clr_o,
   output logic hold_clr_o
);
   logic pos_req;
   logic hold_req;

   assign pos_req    = trig_i & clr_pos_en_i;
   assign hold_req   = trig_i & clr_hold_en_i;
   assign hclr_now_o = hold_req;

   generate
      if (TRIG_REG) begin : g_reg
         logic pos_q;
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pos_q  <= 1'b0;
               hold_q <= 1'b0;
            end else begin
               pos_q  <= pos_req;
               hold_q <= hold_req;
            end
         end
         assign pos_clr_o  = pos_q;
         assign hold_clr_o = hold_q;
      end else begin : g_comb
         assign pos_clr_o  = pos_req;
         assign hold_clr_o = hold_req;
      end
   endgenerate
endmodule

// File: rtl/snap_hold_bank.sv
module snap_hold_bank #(
   parameter int POS_W  = 32,
   parameter int REV_W  = 16,
   parameter int DIFF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snap_i,
   input  logic              hclr_i,
   input  logic [POS_W-1:0]  pos_i,
   input  logic [REV_W-1:0]  rev_i,
   input  logic [DIFF_W-1:0] diff_i,
   output logic [POS_W-1:0]  hold_pos_o,
   output logic [REV_W-1:0]  hold_rev_o,
   output logic [DIFF_W-1:0] hold_diff_o
);
   // Snapshot has priority over the trigger clear of the held position.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_pos_o <= '0;
      end else if (snap_i) begin
         hold_pos_o <= pos_i;
      end else if (hclr_i) begin
         hold_pos_o <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_rev_o  <= '0;
         hold_diff_o <= '0;
      end else if (snap_i) begin
         hold_rev_o  <= rev_i;
         hold_diff_o <= diff_i;
      end
   end
endmodule

// File: rtl/snap_rd_mux.sv
module snap_rd_mux
   import enc_snap_pkg::*;
#(
   parameter int POS_W  = 32,
   parameter int REV_W  = 16,
   parameter int DIFF_W = 16,
   parameter int BUS_W  = 16
) (
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [POS_W-1:0]  pos_i,
   input  logic [REV_W-1:0]  rev_i,
   input  logic [DIFF_W-1:0] diff_i,
   input  logic [POS_W-1:0]  hold_pos_i,
   input  logic [REV_W-1:0]  hold_rev_i,
   input  logic [DIFF_W-1:0] hold_diff_i,
   output logic [BUS_W-1:0]  rd_data_o
);
   localparam int HI_LSB = BUS_W;

   logic [BUS_W-1:0] word;

   always_comb begin
      word = '0;
      case (snap_addr_e'(rd_addr_i))
         A_POS_HI:  word = pos_i[POS_W-1:HI_LSB];
         A_POS_LO:  word = hold_pos_i[BUS_W-1:0];
         A_POSH_HI: word = hold_pos_i[POS_W-1:HI_LSB];
         A_POSH_LO: word = hold_pos_i[BUS_W-1:0];
         A_REV:     word = BUS_W'(rev_i);
         A_REVH:    word = BUS_W'(hold_rev_i);
         A_DIFF:    word = BUS_W'(diff_i);
         A_DIFFH:   word = BUS_W'(hold_diff_i);
         default:   word = '0;
      endcase
   end

   assign rd_data_o = rd_en_i ? word : '0;
endmodule

// File: rtl/enc_snap_hold.sv
module enc_snap_hold
   import enc_snap_pkg::*;
#(
   parameter int POS_W    = 32,
   parameter int REV_W    = 16,
   parameter int DIFF_W   = 16,
   parameter int BUS_W    = 16,
   parameter bit TRIG_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [POS_W-1:0]  pos_i,
   input  logic [REV_W-1:0]  rev_i,
   input  logic [DIFF_W-1:0] diff_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [BUS_W-1:0]  rd_data_o,
   input  logic              trig_i,
   input  logic              clr_pos_en_i,
   input  logic              clr_hold_en_i,
   output logic              pos_clr_o,
   output logic              hold_clr_o
);
   generate
      if (POS_W != 2 * BUS_W) begin : g_bad_pos
         $error("POS_W must be twice BUS_W");
      end
      if (REV_W > BUS_W || REV_W < 1) begin : g_bad_rev
         $error("REV_W must be 1..BUS_W");
      end
      if (DIFF_W > BUS_W || DIFF_W < 1) begin : g_bad_diff
         $error("DIFF_W must be 1..BUS_W");
      end
   endgenerate

   logic              snap;
   logic              hclr_now;
   logic [POS_W-1:0]  hold_pos;
   logic [REV_W-1:0]  hold_rev;
   logic [DIFF_W-1:0] hold_diff;

   assign snap = rd_en_i & is_live_addr(rd_addr_i);

   snap_trig_ctl #(.TRIG_REG(TRIG_REG)) u_trig (
      .clk          (clk),
      .rst_n        (rst_n),
      .trig_i       (trig_i),
      .clr_pos_en_i (clr_pos_en_i),
      .clr_hold_en_i(clr_hold_en_i),
      .hclr_now_o   (hclr_now),
      .pos_clr_o    (pos_clr_o),
      .hold_clr_o   (hold_clr_o)
   );

   snap_hold_bank #(.POS_W(POS_W), .REV_W(REV_W), .DIFF_W(DIFF_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .snap_i     (snap),
      .hclr_i     (hclr_now),
      .pos_i      (pos_i),
      .rev_i      (rev_i),
      .diff_i     (diff_i),
      .hold_pos_o (hold_pos),
      .hold_rev_o (hold_rev),
      .hold_diff_o(hold_diff)
   );

   snap_rd_mux #(.POS_W(POS_W), .REV_W(REV_W), .DIFF_W(DIFF_W), .BUS_W(BUS_W)) u_mux (
      .rd_en_i    (rd_en_i),
      .rd_addr_i  (rd_addr_i),
      .pos_i      (pos_i),
      .rev_i      (rev_i),
      .diff_i     (diff_i),
      .hold_pos_i (hold_pos),
      .hold_rev_i (hold_rev),
      .hold_diff_i(hold_diff),
      .rd_data_o  (rd_data_o)
   );
endmodule

// File: rtl/enc_snap_hold_chk.sv
module enc_snap_hold_chk #(
   parameter int POS_W    = 32,
   parameter int REV_W    = 16,
   parameter int DIFF_W   = 16,
   parameter int BUS_W    = 16,
   parameter bit TRIG_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [POS_W-1:0]  pos_i,
   input logic [REV_W-1:0]  rev_i,
   input logic [DIFF_W-1:0] diff_i,
   input logic              rd_en_i,
   input logic [2:0]        rd_addr_i,
   input logic [BUS_W-1:0]  rd_data_o,
   input logic              trig_i,
   input logic              clr_pos_en_i,
   input logic              clr_hold_en_i,
   input logic              pos_clr_o,
   input logic              hold_clr_o,
   input logic [POS_W-1:0]  hold_pos,
   input logic [REV_W-1:0]  hold_rev,
   input logic [DIFF_W-1:0] hold_diff
);
   logic live_rd;
   assign live_rd = rd_en_i && (rd_addr_i == 3'd0 || rd_addr_i == 3'd1 ||
                                rd_addr_i == 3'd4 || rd_addr_i == 3'd6);

   // R2 and R8: snapshot copies every counter, and wins over a hold clear
   p_snap_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      live_rd |=> (hold_pos == $past(pos_i) && hold_rev == $past(rev_i) &&
                   hold_diff == $past(diff_i)));

   // R3: without a live read, revolution and difference holds do not move
   p_no_snap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !live_rd |=> ($stable(hold_rev) && $stable(hold_diff)));

   // R3: without a live read or hold clear, the held position does not move
   p_pos_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!live_rd && !(trig_i && clr_hold_en_i)) |=> $stable(hold_pos));

   // R7: a trigger clear without a snapshot zeroes the held position
   p_hold_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!live_rd && trig_i && clr_hold_en_i) |=> hold_pos == '0);

   // R9: an idle bus returns zero
   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |-> rd_data_o == '0);

   // R4: the upper position half is taken live
   p_live_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && rd_addr_i == 3'd0) |-> rd_data_o == pos_i[POS_W-1:BUS_W]);

   generate
      if (TRIG_REG) begin : g_reg_chk
         // R6: the position clear pulse follows the enabled trigger by one cycle
         p_pos_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_i && clr_pos_en_i) |=> pos_clr_o);
         p_pos_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(trig_i && clr_pos_en_i) |=> !pos_clr_o);
         // R7: the hold clear pulse follows the enabled trigger by one cycle
         p_hold_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (trig_i && clr_hold_en_i) |=> hold_clr_o);
      end else begin : g_comb_chk
         p_pos_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
            pos_clr_o == (trig_i && clr_pos_en_i));
         p_hold_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hold_clr_o == (trig_i && clr_hold_en_i));
      end
   endgenerate
endmodule

bind enc_snap_hold enc_snap_hold_chk #(
   .POS_W(POS_W), .REV_W(REV_W), .DIFF_W(DIFF_W), .BUS_W(BUS_W), .TRIG_REG(TRIG_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pos_i        (pos_i),
   .rev_i        (rev_i),
   .diff_i       (diff_i),
   .rd_en_i      (rd_en_i),
   .rd_addr_i    (rd_addr_i),
   .rd_data_o    (rd_data_o),
   .trig_i       (trig_i),
   .clr_pos_en_i (clr_pos_en_i),
   .clr_hold_en_i(clr_hold_en_i),
   .pos_clr_o    (pos_clr_o),
   .hold_clr_o   (hold_clr_o),
   .hold_pos     (hold_pos),
   .hold_rev     (hold_rev),
   .hold_diff    (hold_diff)
);

// File: tb/enc_snap_hold_tb.sv
module enc_snap_hold_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pos_i = '0;
   logic [15:0] rev_i = '0;
   logic [15:0] diff_i = '0;
   logic        rd_en_i = 1'b0;
   logic [2:0]  rd_addr_i = '0;
   logic [15:0] rd_data_o;
   logic        trig_i = 1'b0;
   logic        clr_pos_en_i = 1'b0;
   logic        clr_hold_en_i = 1'b0;
   logic        pos_clr_o;
   logic        hold_clr_o;

   int tests = 0;
   int fails = 0;

   // bench model of the hold registers and pending pulses
   logic [31:0] m_pos  = '0;
   logic [15:0] m_rev  = '0;
   logic [15:0] m_diff = '0;
   logic        e_pclr = 1'b0;
   logic        e_hclr = 1'b0;

   always #10 clk = ~clk;

   enc_snap_hold u_dut (
      .clk(clk), .rst_n(rst_n), .pos_i(pos_i), .rev_i(rev_i), .diff_i(diff_i),
      .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
      .trig_i(trig_i), .clr_pos_en_i(clr_pos_en_i), .clr_hold_en_i(clr_hold_en_i),
      .pos_clr_o(pos_clr_o), .hold_clr_o(hold_clr_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word(input logic en, input logic [2:0] a,
                                            input logic [31:0] p, input logic [15:0] r,
                                            input logic [15:0] d);
      if (!en) return 16'h0;
      case (a)
         3'd0: return p[31:16];
         3'd1: return m_pos[15:0];
         3'd2: return m_pos[31:16];
         3'd3: return m_pos[15:0];
         3'd4: return r;
         3'd5: return m_rev;
         3'd6: return d;
         default: return m_diff;
      endcase
   endfunction

   task automatic cyc(input logic [2:0] a, input logic en, input logic tg,
                      input logic cpe, input logic che, input logic [31:0] p,
                      input logic [15:0] r, input logic [15:0] d, input string tag);
      string t;
      logic live;
      @(negedge clk);
      rd_addr_i = a; rd_en_i = en; trig_i = tg; clr_pos_en_i = cpe;
      clr_hold_en_i = che; pos_i = p; rev_i = r; diff_i = d;
      #2;
      if (tag != "") t = tag;
      else if (!en) t = "R9";
      else if (a <= 3'd1) t = "R4";
      else t = "R5";
      check(t, {16'h0, rd_data_o}, {16'h0, exp_word(en, a, p, r, d)});
      check("R6", {31'h0, pos_clr_o}, {31'h0, e_pclr});
      check("R7", {31'h0, hold_clr_o}, {31'h0, e_hclr});
      // model update at the coming edge
      live = en && (a == 3'd0 || a == 3'd1 || a == 3'd4 || a == 3'd6);
      if (live) begin
         m_pos = p; m_rev = r; m_diff = d;   // R2, R8: snapshot first
      end else if (tg && che) begin
         m_pos = '0;                         // R7
      end
      e_pclr = tg && cpe;
      e_hclr = tg && che;
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state of holds and pulses
      cyc(3'd2, 1, 0, 0, 0, 32'hAAAA5555, 16'h1234, 16'h4321, "R1");
      cyc(3'd3, 1, 0, 0, 0, 32'hAAAA5555, 16'h1234, 16'h4321, "R1");
      cyc(3'd5, 1, 0, 0, 0, 32'hAAAA5555, 16'h1234, 16'h4321, "R1");
      cyc(3'd7, 1, 0, 0, 0, 32'hAAAA5555, 16'h1234, 16'h4321, "R1");
      // R2: read of live revolution snapshots all three counters
      cyc(3'd4, 1, 0, 0, 0, 32'h1357_9BDF, 16'h1111, 16'h2222, "");
      cyc(3'd5, 1, 0, 0, 0, 32'hFFFF_0000, 16'h3333, 16'h4444, "R2");
      cyc(3'd2, 1, 0, 0, 0, 32'hFFFF_0000, 16'h3333, 16'h4444, "R2");
      cyc(3'd7, 1, 0, 0, 0, 32'hFFFF_0000, 16'h3333, 16'h4444, "R2");
      // R3: hold reads did not snapshot
      cyc(3'd3, 1, 0, 0, 0, 32'h0F0F_F0F0, 16'h5555, 16'h6666, "R3");
      // R4: split read: upper live then lower from hold
      cyc(3'd0, 1, 0, 0, 0, 32'hCAFE_BABE, 16'h0001, 16'h0002, "R4");
      cyc(3'd1, 1, 0, 0, 0, 32'hCAFF_0001, 16'h0001, 16'h0002, "R4");
      // R7: hold clear without snapshot, revolution hold untouched
      cyc(3'd0, 0, 1, 0, 1, 32'h0, 16'h0, 16'h0, "R9");
      cyc(3'd3, 1, 0, 0, 0, 32'h0, 16'h0, 16'h0, "R7");
      cyc(3'd5, 1, 0, 0, 0, 32'h0, 16'h0, 16'h0, "R7");
      // R8: snapshot and hold clear on the same edge
      cyc(3'd0, 1, 1, 1, 1, 32'h8765_4321, 16'h0, 16'h0, "R4");
      cyc(3'd2, 1, 0, 0, 0, 32'h0, 16'h0, 16'h0, "R8");
      cyc(3'd3, 1, 0, 0, 0, 32'h0, 16'h0, 16'h0, "R8");
      // R6: trigger with disabled clears gives no pulse
      cyc(3'd2, 0, 1, 0, 0, 32'h0, 16'h0, 16'h0, "R9");
      cyc(3'd2, 1, 0, 0, 0, 32'h0, 16'h0, 16'h0, "R6");
      // sweep: every address, enable, trigger and clear-enable combination
      for (int k = 0; k < 4; k++) begin
         for (int i = 0; i < 64; i++) begin
            logic [31:0] p;
            p = (32'(i + 64 * k) * 32'h9E3779B9) ^ 32'h5A5A1234;
            cyc(3'(i % 8), (i / 8) % 2 == 1, (i / 16) % 2 == 1,
                (i / 32) % 2 == 1, ((i + k) % 3) == 0,
                p, p[15:0] ^ 16'hA5A5, p[31:16] + 16'(i), "");
         end
      end
      // final drain of hold contents
      cyc(3'd2, 1, 0, 0, 0, 32'h0, 16'h0, 16'h0, "R5");
      cyc(3'd3, 1, 0, 0, 0, 32'h0, 16'h0, 16'h0, "R5");
      cyc(3'd5, 1, 0, 0, 0, 32'h0, 16'h0, 16'h0, "R5");
      cyc(3'd7, 1, 0, 0, 0, 32'h0, 16'h0, 16'h0, "R5");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule